// File: doc/BRIEF.md
# External Bus Hold Arbiter

This block decides when an outside master may take the external memory bus away from the core. The outside master pulls an active-low hold request line. If the block agrees, it answers on an active-low hold acknowledge line and turns on the tri-state enable for the external interface. While the outside master owns the bus, the core keeps running from internal memory. Any core attempt to reach the external bus is held off by a not-ready signal until the request goes away.

Software controls the block through a small register port. One writable bit disables automatic granting. Setting it while the bus is granted takes the bus back at the clock edge that stores the write. Two read-only bits report the synchronized request level and the live acknowledge level. The request passes through a synchronizer before it is used. A new grant is issued only when no external bus cycle is running, and only when no core access is being launched.

A request that is already active while reset is held gets the bus during reset. It keeps the bus without a gap when reset is released.

Top module: `extbus_hold_arb`

## Requirements
- R1: `bus_hiz_o` is 1 in exactly the cycles where `ack_n_o` is 0. A grant is shown by `ack_n_o` = 0.
- R2: While the hold-disable bit (register bit 0) is 1, no grant is given and `ack_n_o` stays 1, even with `req_n_i` held low.
- R3: With the hold-disable bit at 0 and `xbus_busy_i` at 0, a low `req_n_i` drives `ack_n_o` low. This happens SYNC_STAGES+1 rising edges after the input changes (3 edges by default).
- R4: Writing 1 to register bit 0 while granted drives `ack_n_o` high and `bus_hiz_o` low at the edge that stores the write. Writing 0 while the synchronized request is still low grants again at the edge that stores that write.
- R5: While `rst_n` is low, the hold-disable bit is cleared, and each rising edge sets `ack_n_o` to the current `req_n_i` level. So with a low request, `ack_n_o` is 0 and `bus_hiz_o` is 1 during reset, and the grant holds unbroken after reset is released.
- R6: A grant is not issued while `xbus_busy_i` is 1. It is issued at the first rising edge at which `xbus_busy_i` is 0.
- R7: `core_nrdy_o` is 1 while `core_xreq_i` is 1 and the bus is granted, or a grant is being issued in that cycle. With no grant, no release just made, and no grant pending, a core request sees `core_nrdy_o` = 0.
- R8: When `req_n_i` returns high, `ack_n_o` returns high SYNC_STAGES+1 edges later. `core_nrdy_o` for a waiting core request stays 1 for one more edge, then falls.
- R9: `reg_rdata_o` has bit 0 = hold-disable, bit 1 = synchronized request level (active low), bit 2 = `ack_n_o`, and all higher bits 0. A write changes only bit 0, and the other write data bits are ignored.
- R10: `core_nrdy_o` is 0 whenever `core_xreq_i` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_n_i | input | 1 | Hold request from outside master, active low, asynchronous |
| ack_n_o | output | 1 | Hold acknowledge, active low |
| bus_hiz_o | output | 1 | Tri-state enable for external bus signals and strobes |
| xbus_busy_i | input | 1 | An external bus cycle is in progress |
| core_xreq_i | input | 1 | Core is requesting an external bus access |
| core_nrdy_o | output | 1 | Not-ready to the core; stalls the external access |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | REG_W | Register write data (bit 0 used) |
| reg_rdata_o | output | REG_W | Register read data: control and status |

## Verification
On every cycle the assertions check these rules:
- A set hold-disable bit never coexists with a grant.
- A revoking write always releases at its own edge.
- A grant never starts over a busy bus.
- A synchronized request that goes away is released on the next edge.
- A granted bus always stalls a core request.
- The stall clears once the acknowledge has been high for two cycles.

Only the bench's scenarios can show the rest:
- The end-to-end latency through the synchronizer.
- A grant that is carried through reset.
- The exact cycle the stall is freed after a release.
- The register read-back layout, including the ignored write bits.
- The swept delay of the grant behind a busy bus.

// File: rtl/hold_pkg.sv
package hold_pkg;
    // Register field positions shared by the top and its neighbours.
    localparam int unsigned HOLD_POS = 0;
    localparam int unsigned REQ_POS  = 1;
    localparam int unsigned ACK_POS  = 2;
    localparam int unsigned MIN_REG_W = 3;

    typedef struct packed {
        logic ack_n;
        logic hold;
    } grant_st_t;

    typedef struct packed {
        logic owned;
    } stall_st_t;
endpackage

// File: rtl/hold_sync.sv
module hold_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_st_t;

    sync_st_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (!rst_n) begin
            // Preload every stage so a request active in reset survives release.
            nxt_d.chain = {STAGES{d_i}};
        end else begin
            nxt_d.chain = (cur_q.chain << 1) | STAGES'(d_i);
        end
    end

    always_ff @(posedge clk) begin
        cur_q <= nxt_d;
    end

    assign q_o = cur_q.chain[STAGES-1];
endmodule

// File: rtl/hold_grant.sv
module hold_grant
    import hold_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_raw_n_i,
    input  logic req_s_n_i,
    input  logic busy_i,
    input  logic wr_i,
    input  logic wbit_i,
    output logic ack_n_o,
    output logic hold_o,
    output logic grant_now_o
);
    grant_st_t cur_q, nxt_d;
    logic      grant_now;

    always_comb begin
        nxt_d     = cur_q;
        grant_now = 1'b0;
        if (!rst_n) begin
            nxt_d.hold  = 1'b0;
            nxt_d.ack_n = req_raw_n_i;
        end else begin
            if (wr_i) begin
                nxt_d.hold = wbit_i;
            end
            grant_now = cur_q.ack_n && !req_s_n_i && !nxt_d.hold && !busy_i;
            if (cur_q.ack_n) begin
                if (grant_now) begin
                    nxt_d.ack_n = 1'b0;
                end
            end else if (req_s_n_i || nxt_d.hold) begin
                nxt_d.ack_n = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        cur_q <= nxt_d;
    end

    assign ack_n_o     = cur_q.ack_n;
    assign hold_o      = cur_q.hold;
    assign grant_now_o = grant_now;

    // R2: a set disable bit never coexists with a grant
    assert_blocked_no_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q.hold |-> cur_q.ack_n);

    // R4: a revoking write releases at its own edge
    assert_revoke_at_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && wbit_i) |=> cur_q.ack_n);

    // R6: grants only start over an idle bus
    assert_grant_idle_bus_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $fell(cur_q.ack_n)) |-> $past(!busy_i));

    // R8: withdrawn synchronized request is released next edge
    assert_release_next_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cur_q.ack_n && req_s_n_i) |=> cur_q.ack_n);
endmodule

// File: rtl/hold_stall.sv
module hold_stall
    import hold_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ack_n_i,
    input  logic grant_now_i,
    input  logic xreq_i,
    output logic nrdy_o
);
    stall_st_t cur_q, nxt_d;

    always_comb begin
        nxt_d       = cur_q;
        // Ownership lags the acknowledge by one cycle so the stall outlives it.
        nxt_d.owned = !ack_n_i;
    end

    always_ff @(posedge clk) begin
        cur_q <= nxt_d;
    end

    assign nrdy_o = xreq_i && (!ack_n_i || cur_q.owned || grant_now_i);

    // R7: granted bus always stalls a core request
    assert_stall_when_granted_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (xreq_i && !ack_n_i) |-> nrdy_o);

    // R8: stall clears after two released cycles
    assert_stall_freed_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ack_n_i && $past(ack_n_i) && !grant_now_i) |-> !nrdy_o);
endmodule

// File: rtl/extbus_hold_arb.sv
module extbus_hold_arb
    import hold_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned REG_W       = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_n_i,
    output logic             ack_n_o,
    output logic             bus_hiz_o,
    input  logic             xbus_busy_i,
    input  logic             core_xreq_i,
    output logic             core_nrdy_o,
    input  logic             reg_wr_i,
    input  logic [REG_W-1:0] reg_wdata_i,
    output logic [REG_W-1:0] reg_rdata_o
);
    logic req_s_n;
    logic ack_n;
    logic hold;
    logic grant_now;
    logic unused_wbits;

    initial begin
        assert_reg_width_R9: assert (REG_W >= MIN_REG_W && SYNC_STAGES >= 1);
    end

    hold_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (req_n_i),
        .q_o   (req_s_n)
    );

    hold_grant u_grant (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_raw_n_i (req_n_i),
        .req_s_n_i   (req_s_n),
        .busy_i      (xbus_busy_i),
        .wr_i        (reg_wr_i),
        .wbit_i      (reg_wdata_i[HOLD_POS]),
        .ack_n_o     (ack_n),
        .hold_o      (hold),
        .grant_now_o (grant_now)
    );

    hold_stall u_stall (
        .clk         (clk),
        .rst_n       (rst_n),
        .ack_n_i     (ack_n),
        .grant_now_i (grant_now),
        .xreq_i      (core_xreq_i),
        .nrdy_o      (core_nrdy_o)
    );

    assign unused_wbits = ^reg_wdata_i;
    assign ack_n_o      = ack_n;
    assign bus_hiz_o    = !ack_n;

    always_comb begin
        reg_rdata_o           = '0;
        reg_rdata_o[HOLD_POS] = hold;
        reg_rdata_o[REQ_POS]  = req_s_n;
        reg_rdata_o[ACK_POS]  = ack_n;
    end
endmodule

// File: tb/sim_extbus_hold_arb.sv
`timescale 1ns/100ps
module sim_extbus_hold_arb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_n = 1'b1;
    logic       busy = 1'b0;
    logic       xreq = 1'b0;
    logic       wr = 1'b0;
    logic [3:0] wdata = 4'h0;
    logic       ack_n, hiz, nrdy;
    logic [3:0] rdata;
    int         n_cmp = 0;
    int         n_bad = 0;

    always #2.5 clk = ~clk;

    extbus_hold_arb #(.SYNC_STAGES(2), .REG_W(4)) u0 (
        .clk(clk), .rst_n(rst_n), .req_n_i(req_n), .ack_n_o(ack_n),
        .bus_hiz_o(hiz), .xbus_busy_i(busy), .core_xreq_i(xreq),
        .core_nrdy_o(nrdy), .reg_wr_i(wr), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk_grant(input string tag, input logic exp_ack);
        chk({tag, " ack"}, 32'(ack_n), 32'(exp_ack));
        chk({"R1 hiz ", tag}, 32'(hiz), 32'(!exp_ack));
    endtask

    task automatic wr_reg(input logic [3:0] v);
        wr = 1'b1;
        wdata = v;
        step(1);
        wr = 1'b0;
        wdata = 4'h0;
    endtask

    initial begin
        #100000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // R5: reset state with idle request
        step(3);
        chk_grant("R5 reset idle", 1'b1);
        chk("R5 R9 reset rdata", 32'(rdata), 32'h6);
        rst_n = 1'b1;
        step(1);
        xreq = 1'b1;
        #1 chk("R7 no stall when ungranted", 32'(nrdy), 32'h0);
        xreq = 1'b0;
        #1 chk("R10 no request no stall", 32'(nrdy), 32'h0);

        // R3: grant latency through synchronizer
        req_n = 1'b0;
        step(2);
        chk_grant("R3 before latency", 1'b1);
        step(1);
        chk_grant("R3 at latency", 1'b0);
        chk("R9 granted rdata", 32'(rdata), 32'h0);
        xreq = 1'b1;
        #1 chk("R7 stall while granted", 32'(nrdy), 32'h1);

        // R8: release sequencing
        req_n = 1'b1;
        step(2);
        chk_grant("R8 still held", 1'b0);
        chk("R9 sync req status", 32'(rdata), 32'h2);
        step(1);
        chk_grant("R8 released", 1'b1);
        chk("R8 stall one more cycle", 32'(nrdy), 32'h1);
        step(1);
        chk("R8 stall freed", 32'(nrdy), 32'h0);
        xreq = 1'b0;

        // R2, R9: disable bit blocks grant, upper write bits ignored
        wr_reg(4'hF);
        chk("R9 write only bit0", 32'(rdata), 32'h7);
        req_n = 1'b0;
        step(6);
        chk_grant("R2 blocked", 1'b1);
        chk("R2 rdata blocked", 32'(rdata), 32'h5);

        // R4: clear regrants at the write edge; set revokes at the write edge
        wr_reg(4'hE);
        chk_grant("R4 regrant on clear", 1'b0);
        chk("R9 rdata after clear", 32'(rdata), 32'h0);
        wr_reg(4'h1);
        chk_grant("R4 revoke", 1'b1);
        wr_reg(4'h0);
        chk_grant("R4 regrant again", 1'b0);
        req_n = 1'b1;
        step(3);
        chk_grant("R8 release after revoke test", 1'b1);

        // R6: sweep busy duration; grant one edge after busy drops
        for (int d = 0; d < 6; d++) begin
            busy = 1'b1;
            req_n = 1'b0;
            step(3 + d);
            chk_grant($sformatf("R6 busy wait d=%0d", d), 1'b1);
            busy = 1'b0;
            step(1);
            chk_grant($sformatf("R6 grant after busy d=%0d", d), 1'b0);
            req_n = 1'b1;
            step(3);
            chk_grant($sformatf("R8 release d=%0d", d), 1'b1);
            step(1);
        end

        // R7: stall during the cycle a grant is issued
        xreq = 1'b1;
        req_n = 1'b0;
        step(2);
        #1 chk("R7 stall on pending grant", 32'(nrdy), 32'h1);
        chk_grant("R7 pending not yet granted", 1'b1);
        step(1);
        chk_grant("R3 pending grant issued", 1'b0);
        xreq = 1'b0;
        #1 chk("R10 granted but no request", 32'(nrdy), 32'h0);
        req_n = 1'b1;
        step(4);

        // R5: request active in reset is granted and carried through release
        wr_reg(4'h1);
        rst_n = 1'b0;
        req_n = 1'b0;
        step(2);
        chk_grant("R5 granted in reset", 1'b0);
        chk("R5 disable bit cleared", 32'(rdata), 32'h0);
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++) begin
            step(1);
            chk_grant($sformatf("R5 held after reset %0d", i), 1'b0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule